// File: doc/BRIEF.md
# Configuration Lock Key Register

This block is the register-bus slave that guards the configuration of one general-purpose I/O port. It holds one lock bit per pin and a key bit. The key can only be armed by a fixed three-write handshake on the lock register. Once the key is armed, the pins whose lock bits are set keep their configuration until reset. A plain single write cannot arm it by mistake.

The slave has a simple 32-bit write/read port with byte strobes and a combinational read path. It contains a compact model of the port's configuration fields: drive mode, output type, slew setting, pull selection and alternate-function number. Each field write is gated by the pin's freeze bit. The per-pin freeze mask is also driven out, so neighbouring logic can honour the same lock.

Top module: `cfg_lock_key_reg`

## Requirements
- R1: After reset every mapped register reads 0x0000_0000, `freeze_mask` is all zero and `lock_active` is 0.
- R2: The lock register is at address 6. Bit 16 is the key, bits NPIN-1:0 are the per-pin lock bits, and bits 31:17 always read as zero whatever was written.
- R3: While the key is 0, a write to the lock register updates the lock bits under byte strobes: bits 7:0 with `bus_be[0]` and bits 15:8 with `bus_be[1]`. No single write ever sets the key.
- R4: The key becomes 1 on the clock edge of the third of three consecutive full-word (`bus_be` = 4'b1111) writes to the lock register that carry bit 16 = 1, then 0, then 1, with identical bits 15:0.
- R5: A handshake write whose bits 15:0 differ from the current lock bits aborts the handshake.
- R6: A handshake write with any byte strobe cleared aborts the handshake.
- R7: Any write to another address aborts the handshake, and so does any write out of order. An aborting write that has bit 16 = 1 and full strobes counts as step one of a new handshake.
- R8: Reads and idle cycles between handshake writes do not disturb the handshake.
- R9: Once set, the key stays 1 until reset. While it is 1, the lock bits ignore every write.
- R10: `freeze_mask` equals the lock bits while the key is 1, and is all zero while the key is 0.
- R11: A configuration field of a frozen pin ignores writes. Fields of other pins are written under byte strobes.
- R12: Configuration map: drive mode is 2 bits per pin at address 0, output type is 1 bit per pin at address 1, slew is 2 bits per pin at address 2, and pull is 2 bits per pin at address 3. The alternate function is 4 bits per pin, with pins 0-7 at address 4 and pins 8-15 at address 5. Pin p's field starts at bit (p mod pins-per-word) × width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address for write and read |
| bus_be | input | 4 | Byte strobes of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| freeze_mask | output | NPIN | Pins whose configuration is frozen |
| lock_active | output | 1 | Key bit, set after a successful handshake |

## Verification
The properties assume a single-cycle write strobe with address, strobes and data stable while it is high. They also assume that only reset clears the key, so they can treat the key as monotonic. The stimulus drives every bus input on the falling edge and holds it for one full cycle per write. It samples the combinational read data a moment after the address settles and never near a rising edge. Each scenario starts from a fresh reset, because the key cannot be cleared any other way.

// File: rtl/cfglk_pkg.sv
package cfglk_pkg;
   localparam int BUS_W   = 32;
   localparam int KEY_POS = 16;

   localparam int ADR_MODE  = 0;
   localparam int ADR_OTYPE = 1;
   localparam int ADR_SPEED = 2;
   localparam int ADR_PULL  = 3;
   localparam int ADR_AF    = 4;
   localparam int ADR_LOCK  = 6;

   localparam int W_MODE  = 2;
   localparam int W_OTYPE = 1;
   localparam int W_SPEED = 2;
   localparam int W_PULL  = 2;
   localparam int W_AF    = 4;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_HAVE1 = 2'd1,
      SEQ_HAVE0 = 2'd2
   } seq_e;
endpackage

// File: rtl/cfglk_field_bank.sv
module cfglk_field_bank
   import cfglk_pkg::*;
#(
   parameter int NPIN   = 16,
   parameter int FW     = 2,
   parameter int BASE   = 0,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [3:0]        be_i,
   input  logic [BUS_W-1:0]  wdata_i,
   input  logic [NPIN-1:0]   freeze_i,
   output logic [BUS_W-1:0]  rdata_o
);
   localparam int PER_REG = BUS_W / FW;

   generate
      if (FW < 1 || FW > 8 || (8 % FW) != 0) begin : g_bad_fw
         $error("cfglk_field_bank: field width must divide a byte");
      end
   endgenerate

   logic [NPIN*FW-1:0] flat_q;

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      localparam int OFS = (p % PER_REG) * FW;
      localparam logic [ADDR_W-1:0] ADR = ADDR_W'(BASE + p / PER_REG);
      logic          we;
      logic [FW-1:0] q;

      assign we = wr_i && (addr_i == ADR) && be_i[OFS/8] && !freeze_i[p];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q <= '0;
         else if (we) q <= wdata_i[OFS +: FW];
      end

      assign flat_q[p*FW +: FW] = q;
   end

   always_comb begin
      rdata_o = '0;
      for (int p = 0; p < NPIN; p++) begin
         if (addr_i == ADDR_W'(BASE + p / PER_REG))
            rdata_o[(p % PER_REG)*FW +: FW] = flat_q[p*FW +: FW];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/cfglk_lock_bits.sv
module cfglk_lock_bits #(
   parameter int NPIN = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [1:0]      be_i,
   input  logic [NPIN-1:0] data_i,
   output logic [NPIN-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (we_i) begin
         for (int p = 0; p < NPIN; p++)
            if (be_i[p/8]) q_o[p] <= data_i[p];
      end
   end
endmodule

// File: rtl/cfglk_key_seq.sv
module cfglk_key_seq
   import cfglk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic lock_hit_i,
   input  logic full_i,
   input  logic key_bit_i,
   input  logic same_i,
   output logic key_o
);
   seq_e st_q, st_d;
   logic set_d;

   always_comb begin
      st_d  = st_q;
      set_d = 1'b0;
      if (wr_i) begin
         if (key_o || !lock_hit_i || !full_i) begin
            st_d = SEQ_IDLE;
         end else begin
            unique case (st_q)
               SEQ_HAVE1: begin
                  if (!key_bit_i && same_i) st_d = SEQ_HAVE0;
                  else                      st_d = key_bit_i ? SEQ_HAVE1 : SEQ_IDLE;
               end
               SEQ_HAVE0: begin
                  if (key_bit_i && same_i) begin
                     set_d = 1'b1;
                     st_d  = SEQ_IDLE;
                  end else begin
                     st_d = key_bit_i ? SEQ_HAVE1 : SEQ_IDLE;
                  end
               end
               default: st_d = key_bit_i ? SEQ_HAVE1 : SEQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         key_o <= 1'b0;
      end else begin
         st_q <= st_d;
         if (set_d) key_o <= 1'b1;
      end
   end
endmodule

// File: rtl/cfg_lock_key_reg.sv
module cfg_lock_key_reg
   import cfglk_pkg::*;
#(
   parameter int NPIN   = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NPIN-1:0]   freeze_mask,
   output logic              lock_active
);
   localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(ADR_LOCK);

   generate
      if (NPIN < 1 || NPIN > KEY_POS) begin : g_bad_npin
         $error("cfg_lock_key_reg: NPIN must be 1..16");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("cfg_lock_key_reg: ADDR_W too small for the map");
      end
   endgenerate

   logic            lock_hit, full_wr, same_mask, lock_we;
   logic [NPIN-1:0] lock_q;

   assign lock_hit  = (bus_addr == LOCK_A);
   assign full_wr   = &bus_be;
   assign same_mask = (bus_wdata[NPIN-1:0] == lock_q);
   assign lock_we   = bus_wr && lock_hit && !lock_active;

   cfglk_lock_bits #(.NPIN(NPIN)) u_bits (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (lock_we),
      .be_i  (bus_be[1:0]),
      .data_i(bus_wdata[NPIN-1:0]),
      .q_o   (lock_q)
   );

   cfglk_key_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr),
      .lock_hit_i(lock_hit),
      .full_i    (full_wr),
      .key_bit_i (bus_wdata[KEY_POS]),
      .same_i    (same_mask),
      .key_o     (lock_active)
   );

   assign freeze_mask = lock_active ? lock_q : '0;

   logic [BUS_W-1:0] r_mode, r_otype, r_speed, r_pull, r_af, r_lock;

   cfglk_field_bank #(.NPIN(NPIN), .FW(W_MODE), .BASE(ADR_MODE), .ADDR_W(ADDR_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .be_i(bus_be),
      .wdata_i(bus_wdata), .freeze_i(freeze_mask), .rdata_o(r_mode));
   cfglk_field_bank #(.NPIN(NPIN), .FW(W_OTYPE), .BASE(ADR_OTYPE), .ADDR_W(ADDR_W)) u_otype (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .be_i(bus_be),
      .wdata_i(bus_wdata), .freeze_i(freeze_mask), .rdata_o(r_otype));
   cfglk_field_bank #(.NPIN(NPIN), .FW(W_SPEED), .BASE(ADR_SPEED), .ADDR_W(ADDR_W)) u_speed (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .be_i(bus_be),
      .wdata_i(bus_wdata), .freeze_i(freeze_mask), .rdata_o(r_speed));
   cfglk_field_bank #(.NPIN(NPIN), .FW(W_PULL), .BASE(ADR_PULL), .ADDR_W(ADDR_W)) u_pull (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .be_i(bus_be),
      .wdata_i(bus_wdata), .freeze_i(freeze_mask), .rdata_o(r_pull));
   cfglk_field_bank #(.NPIN(NPIN), .FW(W_AF), .BASE(ADR_AF), .ADDR_W(ADDR_W)) u_af (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .be_i(bus_be),
      .wdata_i(bus_wdata), .freeze_i(freeze_mask), .rdata_o(r_af));

   always_comb begin
      r_lock = '0;
      if (lock_hit) begin
         r_lock[KEY_POS]  = lock_active;
         r_lock[NPIN-1:0] = lock_q;
      end
   end

   assign bus_rdata = r_mode | r_otype | r_speed | r_pull | r_af | r_lock;
endmodule

// File: rtl/cfglk_chk.sv
module cfglk_chk
   import cfglk_pkg::*;
#(
   parameter int NPIN   = 16,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_be,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [NPIN-1:0]   freeze_mask,
   input logic              lock_active
);
   localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(ADR_LOCK);

   // R9
   key_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_active |=> lock_active);

   // R9
   mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_active |=> $stable(freeze_mask));

   // R4
   key_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_active) |-> $past(bus_wr && bus_addr == LOCK_A && bus_be == 4'b1111
                                   && bus_wdata[KEY_POS]));

   // R10
   idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_active |-> freeze_mask == '0);

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == LOCK_A |-> bus_rdata[31:KEY_POS+1] == '0);

   // R10
   mask_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_active && bus_addr == LOCK_A) |-> (bus_rdata[NPIN-1:0] == freeze_mask
                                               && bus_rdata[KEY_POS]));
endmodule

bind cfg_lock_key_reg cfglk_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_cfg_lock_key_reg.sv
module sim_cfg_lock_key_reg;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] A_MODE = 3'd0, A_OTYPE = 3'd1, A_SPEED = 3'd2,
                          A_PULL = 3'd3, A_AFL = 3'd4, A_AFH = 3'd5, A_LOCK = 3'd6;
   localparam logic [31:0] K1 = 32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] freeze_mask;
   logic        lock_active;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_lock_key_reg u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .freeze_mask(freeze_mask),
      .lock_active(lock_active));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bus_wr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic key_seq(input logic [15:0] m);
      wr(A_LOCK, K1 | 32'(m), 4'hF);
      wr(A_LOCK, 32'(m), 4'hF);
      wr(A_LOCK, K1 | 32'(m), 4'hF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      for (int a = 0; a < 7; a++) begin
         rd(3'(a), d);
         chk($sformatf("R1 reset addr %0d", a), d, 32'h0);
      end
      chk("R1 reset freeze", 32'(freeze_mask), 32'h0);
      chk("R1 reset key", 32'(lock_active), 32'h0);
   endtask

   task automatic t_layout_bytes();
      logic [31:0] d;
      do_reset();
      wr(A_LOCK, 32'hFFFF_FFFF, 4'hF);
      rd(A_LOCK, d);
      chk("R2 reserved bits read zero, single write no key", d, 32'h0000_FFFF);
      do_reset();
      wr(A_LOCK, 32'h0000_12AB, 4'b0001);
      rd(A_LOCK, d);
      chk("R3 low byte strobe", d, 32'h0000_00AB);
      wr(A_LOCK, 32'h0001_3400, 4'b0010);
      rd(A_LOCK, d);
      chk("R3 high byte strobe, key not set", d, 32'h0000_34AB);
      chk("R10 lock bits without key do not freeze", 32'(freeze_mask), 32'h0);
   endtask

   task automatic t_lock_ok();
      logic [31:0] d;
      do_reset();
      wr(A_MODE, 32'hFFFF_FFFF, 4'hF);
      wr(A_OTYPE, 32'hFFFF_FFFF, 4'hF);
      wr(A_AFL, 32'hFFFF_FFFF, 4'hF);
      wr(A_AFH, 32'hFFFF_FFFF, 4'hF);
      rd(A_OTYPE, d);
      chk("R12 output type is 1 bit per pin", d, 32'h0000_FFFF);
      key_seq(16'h0005);
      chk("R4 key set after third write", 32'(lock_active), 32'h1);
      chk("R10 freeze mask equals lock bits", 32'(freeze_mask), 32'h0000_0005);
      rd(A_LOCK, d);
      chk("R4 lock register readback", d, 32'h0001_0005);
      wr(A_MODE, 32'h0, 4'hF);
      rd(A_MODE, d);
      chk("R11 mode of frozen pins kept", d, 32'h0000_0033);
      wr(A_OTYPE, 32'h0, 4'hF);
      rd(A_OTYPE, d);
      chk("R11 output type of frozen pins kept", d, 32'h0000_0005);
      wr(A_AFL, 32'h0, 4'hF);
      rd(A_AFL, d);
      chk("R11 alternate function of frozen pins kept", d, 32'h0000_0F0F);
      wr(A_AFH, 32'h0, 4'hF);
      rd(A_AFH, d);
      chk("R11 unfrozen high pins writable", d, 32'h0);
      wr(A_LOCK, 32'h0, 4'hF);
      wr(A_LOCK, 32'h0000_FFFF, 4'hF);
      rd(A_LOCK, d);
      chk("R9 key and lock bits ignore writes", d, 32'h0001_0005);
      do_reset();
      rd(A_LOCK, d);
      chk("R9 reset clears key", d, 32'h0);
   endtask

   task automatic t_abort_mask();
      logic [31:0] d;
      do_reset();
      wr(A_LOCK, K1 | 32'h3, 4'hF);
      wr(A_LOCK, 32'h7, 4'hF);
      wr(A_LOCK, K1 | 32'h7, 4'hF);
      rd(A_LOCK, d);
      chk("R5 changed mask aborts", d, 32'h0000_0007);
      wr(A_LOCK, 32'h7, 4'hF);
      wr(A_LOCK, K1 | 32'h7, 4'hF);
      chk("R7 aborting write with key bit restarts as step one", 32'(lock_active), 32'h1);
   endtask

   task automatic t_abort_partial();
      logic [31:0] d;
      do_reset();
      wr(A_LOCK, K1 | 32'h5, 4'hF);
      wr(A_LOCK, 32'h5, 4'b0011);
      wr(A_LOCK, K1 | 32'h5, 4'hF);
      rd(A_LOCK, d);
      chk("R6 partial write aborts", d, 32'h0000_0005);
   endtask

   task automatic t_abort_other();
      logic [31:0] d;
      do_reset();
      wr(A_LOCK, K1 | 32'h5, 4'hF);
      wr(A_SPEED, 32'h0000_000C, 4'hF);
      wr(A_LOCK, 32'h5, 4'hF);
      wr(A_LOCK, K1 | 32'h5, 4'hF);
      rd(A_LOCK, d);
      chk("R7 write elsewhere aborts", d, 32'h0000_0005);
      rd(A_SPEED, d);
      chk("R12 slew field of pin 1", d, 32'h0000_000C);
      do_reset();
      wr(A_LOCK, K1 | 32'h5, 4'hF);
      wr(A_LOCK, 32'h5, 4'hF);
      wr(A_LOCK, 32'h5, 4'hF);
      wr(A_LOCK, K1 | 32'h5, 4'hF);
      chk("R7 out-of-order write aborts", 32'(lock_active), 32'h0);
   endtask

   task automatic t_restart();
      do_reset();
      wr(A_LOCK, K1 | 32'h0011, 4'hF);
      wr(A_LOCK, K1 | 32'h8000, 4'hF);
      wr(A_LOCK, 32'h8000, 4'hF);
      wr(A_LOCK, K1 | 32'h8000, 4'hF);
      chk("R7 restart locks with new mask", 32'(freeze_mask), 32'h0000_8000);
   endtask

   task automatic t_reads();
      logic [31:0] d;
      do_reset();
      wr(A_LOCK, K1 | 32'h9, 4'hF);
      rd(A_MODE, d);
      rd(A_LOCK, d);
      repeat (3) @(negedge clk);
      wr(A_LOCK, 32'h9, 4'hF);
      rd(A_PULL, d);
      wr(A_LOCK, K1 | 32'h9, 4'hF);
      chk("R8 reads and idle cycles keep the handshake", 32'(lock_active), 32'h1);
   endtask

   task automatic t_cfg_unlocked();
      logic [31:0] d;
      do_reset();
      wr(A_MODE, 32'hFFFF_FFFF, 4'b0100);
      rd(A_MODE, d);
      chk("R11 byte strobe on config register", d, 32'h00FF_0000);
      wr(A_PULL, 32'h8000_0000, 4'hF);
      rd(A_PULL, d);
      chk("R12 pull field of pin 15", d, 32'h8000_0000);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_layout_bytes();
      t_lock_ok();
      t_abort_mask();
      t_abort_partial();
      t_abort_other();
      t_restart();
      t_reads();
      t_cfg_unlocked();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule